// File: doc/BRIEF.md
# Write-Once Timebase Clock Divider

This block produces the slow timing enable that paces program and erase algorithms in a nonvolatile memory controller. Oscillator ticks arrive as a clock enable (`osc_en`) in the system clock domain. They pass through an optional divide-by-8 prescaler and then a 6-bit programmable divider. The block emits a single-cycle pulse on `clk_tick` each time a derived period completes.

Software sets the divisor once after reset through a one-register write port. The first write latches the prescale and divider fields and raises a sticky loaded flag. Every later write is dropped. The loaded flag also gates command launch: a command request made before configuration is refused with an access error, and one made afterwards is passed on. All pins are plain control and status; no port carries a data stream, so no valid/ready handshake or back-pressure applies.

Top module: `tbclk_divider`

## Requirements
- R1: After reset, `cfg_rdata` reads 0x00, `div_loaded` is 0 and `clk_tick` is 0.
- R2: The first `cfg_we` after reset stores `cfg_wdata[6]` as the prescale enable and `cfg_wdata[5:0]` as the divider value D. Bit 7 of the write data is not stored. From the next cycle, `cfg_rdata` = {1, prescale, D} and `div_loaded` stays 1 until reset.
- R3: Any write after the first changes neither `cfg_rdata` nor the tick period.
- R4: `clk_tick` stays 0 while `div_loaded` is 0.
- R5: With prescale 0, the tick period is D+1 counted oscillator enables. The first tick follows the D+1-th counted enable after the loading edge. Each tick is visible in the cycle after the edge that counted that enable.
- R6: With prescale 1, the period is 8×(D+1) counted oscillator enables.
- R7: Only clock edges with `osc_en` high advance the divider. Gaps in `osc_en` stretch the period in system clocks but not in counted enables.
- R8: The largest ratio, prescale 1 with D = 63, gives one tick per 512 counted enables.
- R9: `cmd_req` sampled while not loaded gives `cmd_err` = 1 and `cmd_go` = 0 in the next cycle. Once loaded, it gives `cmd_go` = 1 and `cmd_err` = 0 in the next cycle. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | One oscillator tick per high cycle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Write data {ignored, prescale, divider[5:0]} |
| cfg_rdata | output | 8 | Readback {loaded, prescale, divider[5:0]} |
| clk_tick | output | 1 | One-cycle pulse per derived period |
| div_loaded | output | 1 | Configuration has been written since reset |
| cmd_req | input | 1 | Command launch request |
| cmd_go | output | 1 | Request accepted (registered) |
| cmd_err | output | 1 | Request refused, access error (registered) |

## Verification
The hardest state to reach is a long divide with sparse oscillator enables, together with a rejected second write in the middle of a running period. Both depend on counting edges rather than clock cycles. The stimulus drives `osc_en` from a per-phase pattern function: always high, odd edges only, or every third edge. Each phase resets the block to reopen the write-once register, and the bench walks the same pattern forward from the loading edge to predict every tick edge. The late write is issued while ticks from the first setting are still queued, so any change of period shows up as a mismatched edge number.

// File: rtl/tbclk_pkg.sv
package tbclk_pkg;
  localparam int DEF_DIV_W     = 6;
  localparam int DEF_PRE_RATIO = 8;

  typedef enum logic [1:0] {
    VERDICT_IDLE = 2'b00,
    VERDICT_GO   = 2'b01,
    VERDICT_ERR  = 2'b10
  } verdict_e;
endpackage

// File: rtl/tbclk_cfg_reg.sv
module tbclk_cfg_reg #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DIV_W:0]   wr_fields,
  output logic             pre_en,
  output logic [DIV_W-1:0] div_val,
  output logic             loaded
);
  logic             pre_q;
  logic [DIV_W-1:0] div_q;
  logic             loaded_q;
  logic             accept;

  // only the very first strobe after reset is taken
  assign accept = wr_en & ~loaded_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q    <= 1'b0;
      div_q    <= '0;
      loaded_q <= 1'b0;
    end else if (accept) begin
      pre_q    <= wr_fields[DIV_W];
      div_q    <= wr_fields[DIV_W-1:0];
      loaded_q <= 1'b1;
    end
  end

  assign pre_en  = pre_q;
  assign div_val = div_q;
  assign loaded  = loaded_q;
endmodule

// File: rtl/tbclk_prescale.sv
module tbclk_prescale #(
  parameter int PRE_RATIO = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic osc_en,
  input  logic bypass,
  output logic step
);
  generate
    if (PRE_RATIO > 1) begin : g_count
      localparam int PW = $clog2(PRE_RATIO);
      localparam logic [PW-1:0] LAST = PW'(PRE_RATIO - 1);
      logic [PW-1:0] pcnt;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pcnt <= '0;
        end else if (!run || bypass) begin
          pcnt <= '0;
        end else if (osc_en) begin
          pcnt <= (pcnt == LAST) ? '0 : pcnt + 1'b1;
        end
      end

      assign step = run & osc_en & (bypass | (pcnt == LAST));
    end else begin : g_pass
      logic unused_bypass;
      assign unused_bypass = bypass;
      assign step = run & osc_en;
    end
  endgenerate
endmodule

// File: rtl/tbclk_divcnt.sv
module tbclk_divcnt #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             step,
  input  logic [DIV_W-1:0] limit,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic             tick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      tick_q <= 1'b0;
    end else if (!run) begin
      // held at zero until loaded, so the first period is a full one
      cnt    <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      if (step) begin
        if (cnt == limit) begin
          cnt    <= '0;
          tick_q <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign tick = tick_q;
endmodule

// File: rtl/tbclk_cmd_gate.sv
module tbclk_cmd_gate
  import tbclk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic loaded,
  output logic go,
  output logic err
);
  verdict_e verdict_d, verdict_q;

  always_comb begin
    if (!req)        verdict_d = VERDICT_IDLE;
    else if (loaded) verdict_d = VERDICT_GO;
    else             verdict_d = VERDICT_ERR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) verdict_q <= VERDICT_IDLE;
    else        verdict_q <= verdict_d;
  end

  assign go  = (verdict_q == VERDICT_GO);
  assign err = (verdict_q == VERDICT_ERR);
endmodule

// File: rtl/tbclk_divider.sv
module tbclk_divider
  import tbclk_pkg::*;
#(
  parameter int DIV_W     = DEF_DIV_W,
  parameter int PRE_RATIO = DEF_PRE_RATIO,
  localparam int REG_W    = DIV_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_en,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  output logic             clk_tick,
  output logic             div_loaded,
  input  logic             cmd_req,
  output logic             cmd_go,
  output logic             cmd_err
);
  logic             pre_en;
  logic [DIV_W-1:0] div_val;
  logic             loaded;
  logic             step;
  logic             unused_top_bit;

  assign unused_top_bit = cfg_wdata[REG_W-1];

  tbclk_cfg_reg #(.DIV_W(DIV_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_we),
    .wr_fields (cfg_wdata[DIV_W:0]),
    .pre_en    (pre_en),
    .div_val   (div_val),
    .loaded    (loaded)
  );

  tbclk_prescale #(.PRE_RATIO(PRE_RATIO)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (loaded),
    .osc_en (osc_en),
    .bypass (~pre_en),
    .step   (step)
  );

  tbclk_divcnt #(.DIV_W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (loaded),
    .step  (step),
    .limit (div_val),
    .tick  (clk_tick)
  );

  tbclk_cmd_gate u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (cmd_req),
    .loaded (loaded),
    .go     (cmd_go),
    .err    (cmd_err)
  );

  assign cfg_rdata  = {loaded, pre_en, div_val};
  assign div_loaded = loaded;
endmodule

// File: rtl/tbclk_divider_chk.sv
module tbclk_divider_chk #(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [REG_W-1:0] cfg_rdata,
  input logic             clk_tick,
  input logic             div_loaded,
  input logic             cmd_req,
  input logic             cmd_go,
  input logic             cmd_err
);
  // R4
  no_tick_unloaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !div_loaded |-> !clk_tick);

  // R2
  loaded_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_loaded |=> div_loaded);

  // R2
  load_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_loaded) |-> $past(cfg_we));

  // R3
  frozen_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_loaded |=> $stable(cfg_rdata));

  // R9
  refuse_unloaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !div_loaded) |=> (cmd_err && !cmd_go));

  // R9
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_go, cmd_err}));
endmodule

bind tbclk_divider tbclk_divider_chk #(.REG_W(REG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_we     (cfg_we),
  .cfg_rdata  (cfg_rdata),
  .clk_tick   (clk_tick),
  .div_loaded (div_loaded),
  .cmd_req    (cmd_req),
  .cmd_go     (cmd_go),
  .cmd_err    (cmd_err)
);

// File: tb/tb_tbclk_divider.sv
`timescale 1ns/1ps
module tb_tbclk_divider;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_en = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       clk_tick, div_loaded;
  logic       cmd_req = 1'b0;
  logic       cmd_go, cmd_err;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int osc_mode = 0;
  bit strict = 1'b1;
  string cur_tag = "R5";
  int exp_q[$];

  always #2.5 clk = ~clk;

  tbclk_divider dut (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .clk_tick(clk_tick),
    .div_loaded(div_loaded), .cmd_req(cmd_req), .cmd_go(cmd_go), .cmd_err(cmd_err)
  );

  always @(posedge clk) cyc <= cyc + 1;

  function automatic bit osc_at(int k, int mode);
    case (mode)
      1:       return (k % 2) == 1;
      2:       return (k % 3) == 0;
      default: return 1'b1;
    endcase
  endfunction

  always @(negedge clk) osc_en = osc_at(cyc + 1, osc_mode);

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (edge %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor: pop expected tick edges and compare
  always @(negedge clk) begin
    if (rst_n && clk_tick) begin
      if (exp_q.size() > 0) begin
        int e;
        e = exp_q.pop_front();
        chk(cyc == e, cur_tag, cyc, e);
      end else if (strict) begin
        chk(1'b0, "R4", 1, 0);
      end
    end
  end

  task automatic do_reset();
    strict = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    strict = 1'b1;
  endtask

  task automatic write_cfg(logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // driver: load, then push the expected tick edges for count ticks
  task automatic load_and_expect(logic [7:0] v, int count);
    int n, got, k, p;
    n = (v[5:0] + 1) * (v[6] ? 8 : 1);
    write_cfg(v);
    p = cyc;
    got = 0;
    k = p;
    while (got < count) begin
      k++;
      if (osc_at(k, osc_mode)) begin
        n--;
        if (n == 0) begin
          exp_q.push_back(k);
          got++;
          n = (v[5:0] + 1) * (v[6] ? 8 : 1);
        end
      end
    end
  endtask

  task automatic drain(string tag);
    int guard = 0;
    while (exp_q.size() > 0 && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    strict = 1'b0;
  endtask

  task automatic send_cmd(bit exp_go, string tag);
    @(negedge clk);
    cmd_req = 1'b1;
    @(negedge clk);
    cmd_req = 1'b0;
    chk(cmd_go == exp_go, tag, cmd_go, exp_go);
    chk(cmd_err == !exp_go, tag, cmd_err, !exp_go);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    osc_mode = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cfg_rdata == 8'h00, "R1", cfg_rdata, 0);
    chk(div_loaded == 1'b0, "R1", div_loaded, 0);
    chk(clk_tick == 1'b0, "R1", clk_tick, 0);
    // R4 idle unloaded window; any tick is flagged by the monitor
    repeat (20) @(negedge clk);
    chk(clk_tick == 1'b0, "R4", clk_tick, 0);
    // R9 refused before load
    send_cmd(1'b0, "R9");

    // phase A: prescale off, D=3, bit 7 set in write data
    cur_tag = "R5";
    load_and_expect(8'h83, 5);
    chk(cfg_rdata == 8'h83, "R2", cfg_rdata, 8'h83);
    chk(div_loaded == 1'b1, "R2", div_loaded, 1);
    repeat (3) @(negedge clk);
    write_cfg(8'h7F);          // R3 late write dropped
    @(negedge clk);
    chk(cfg_rdata == 8'h83, "R3", cfg_rdata, 8'h83);
    send_cmd(1'b1, "R9");
    drain("R3");

    // phase B: prescale on, D=2, enables on odd edges only
    do_reset();
    chk(cfg_rdata == 8'h00, "R1", cfg_rdata, 0);
    osc_mode = 1;
    cur_tag = "R6";
    load_and_expect(8'h42, 3);
    chk(cfg_rdata == 8'hC2, "R2", cfg_rdata, 8'hC2);
    drain("R7");

    // phase C: largest ratio
    do_reset();
    osc_mode = 0;
    cur_tag = "R8";
    load_and_expect(8'h7F, 2);
    drain("R8");

    // phase D: ratio 1 with every-third-edge enables
    do_reset();
    osc_mode = 2;
    cur_tag = "R7";
    load_and_expect(8'h00, 6);
    chk(cfg_rdata == 8'h80, "R2", cfg_rdata, 8'h80);
    drain("R5");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule